// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is a single communication cell that lets several hardware threads exchange 64-bit words through a small circular queue. A status tag sits beside the queue and holds an empty flag, a full flag, a spare software flag, a cell-type flag, the occupancy count and the log2 of the queue depth. Every access carries a 3-bit view code. The view code picks how the access treats the queue: a raw peek/patch of the entries, a tag read or rewrite, a push/pop that stalls, a push/pop that never stalls, or one of the semaphore-style views. A FIFO cell ignores the semaphore-style views.

A stalling access that meets an empty queue (read) or a full queue (write) returns a one-cycle stall response. The cell also records the requester's ID in a waiting bitmap. The next push or pop that goes through presents the whole bitmap on the wake vector for one cycle and then clears it. This tells the released requesters to retry. All results are registered. Read data, the stall response and the wake vector are valid in the cycle after the clock edge that takes the access.

Top module: `fifo_comm_cell`

## Requirements
- R1: After reset, a tag read returns empty=1, full=0, spare flag=0, cell-type=1, count=0 and the depth field equal to log2(DEPTH) (3 for the default depth of 8).
- R2: A read in view 1 (tag view) returns a word with empty at bit 0, full at bit 1, the spare flag at bit 16, cell-type at bit 17, the count starting at bit 18 and log2(DEPTH) starting at bit 28. All other bits are zero.
- R3: A write in view 1 loads the spare flag from data bit 16, empty from bit 0 and full from bit 1. When the new empty value is 1, the count becomes 0. Entries and the head position are kept.
- R4: A push (view 2 stalling, or view 3 non-stalling, with wr_i) clears empty. If the access does not stall and count < DEPTH, it stores the data at (head+count) mod DEPTH and increments count, and it sets full once count equals DEPTH. A non-stalling push into a queue already holding DEPTH entries drops the data.
- R5: A pop (view 2 or view 3 with rd_i) clears full. If the access does not stall, it returns the head entry, advances the head (mod DEPTH) and decrements count when count > 0, and it returns 0 when count is 0. It sets empty once count is 0.
- R6: A read in view 0 (raw view) returns the head entry and changes neither count nor head.
- R7: A write in view 0 overwrites the newest entry, at (head+count-1) mod DEPTH, only when count > 0. With count 0 it changes nothing.
- R8: A stalling pop while empty=1 gives block_o=1 for one cycle and read data 0. It sets the requester's bit in the waiting bitmap and leaves count, head and entries unchanged.
- R9: A stalling push while full=1 gives block_o=1 for one cycle, records the requester and stores nothing.
- R10: Every push or pop that does not stall drives wake_o with the waiting bitmap for one cycle and then clears the bitmap. A stalled access never drives wake_o.
- R11: Views 4 and 5 (semaphore views) return 0 on reads and change no cell state.
- R12: A read with view code 6 or 7 returns all ones. A write with those codes is ignored.
- R13: When rd_i and wr_i are both high, only the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| view_i | input | 3 | Access view code |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 64 | Write data |
| req_id_i | input | $clog2(NREQ) | ID of the requesting thread |
| rdata_o | output | 64 | Read result, valid the cycle after a read |
| block_o | output | 1 | Stall response, one cycle |
| wake_o | output | NREQ | Requesters to release, one-cycle pulse |

## Verification
The hardest state to reach is one where the tag flags disagree with the real occupancy. Examples are a full flag set on a half-filled queue, or empty cleared with nothing stored. In that state a stalling access stalls or goes through regardless of the actual count. The bench reaches it with tag-view writes that force the flags, then sends stalling pushes and pops from different requester IDs. It then checks which IDs come back on the wake vector and that a pop from a count of zero returns 0 and sets empty again. A second path fills the queue to exactly DEPTH entries and then proves that a dropped push and a stalled push left no trace, by draining every entry in order.

// File: rtl/fcc_pkg.sv
// Shared view codes for the tagged FIFO cell.
package fcc_pkg;
    typedef enum logic [2:0] {
        VW_RAW    = 3'd0,
        VW_TAG    = 3'd1,
        VW_Q_BLK  = 3'd2,
        VW_Q_TRY  = 3'd3,
        VW_SEM_BL = 3'd4,
        VW_SEM_TR = 3'd5
    } view_e;
endpackage

// File: rtl/fcc_store.sv
// Entry storage for the cell: one synchronous write port and one
// asynchronous read port. Assumes DEPTH is a power of two, at least 2.
module fcc_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Clear all entries on reset; otherwise perform the requested write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the addressed entry.
    assign rdata = mem[raddr];
endmodule

// File: rtl/fcc_waitlist.sv
// Bitmap of stalled requesters. A wake request moves the whole bitmap
// onto the wake output for one cycle and clears it. Assumes block_set
// and wake_req are never high together.
module fcc_waitlist #(
    parameter int NREQ = 8,
    localparam int IDW = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            block_set,
    input  logic [IDW-1:0]  block_id,
    input  logic            wake_req,
    output logic [NREQ-1:0] pend,
    output logic [NREQ-1:0] wake
);
    // Record stalled IDs and issue the release pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            wake <= '0;
        end else if (wake_req) begin
            wake <= pend;
            pend <= '0;
        end else begin
            wake <= '0;
            if (block_set) pend[block_id] <= 1'b1;
        end
    end
endmodule

// File: rtl/fifo_comm_cell.sv
// Tagged FIFO communication cell. Decodes the view code of each access,
// updates the tag and queue pointers, and registers the read data, the
// stall response and (through the waitlist) the wake vector.
// Assumes DEPTH is a power of two in [2, 512] and DATA_W >= 36.
module fifo_comm_cell
    import fcc_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    parameter int NREQ   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              view_i,
    input  logic                    rd_i,
    input  logic                    wr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic [$clog2(NREQ)-1:0] req_id_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic                    block_o,
    output logic [NREQ-1:0]         wake_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam int CNT_LSB = 18;
    localparam int LOG_LSB = 28;

    logic [AW-1:0] head, head_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          e_flag, e_n, f_flag, f_n, t_flag, t_n;
    logic          st_we;
    logic [AW-1:0] st_waddr, tail_a, newest_a;
    logic [DATA_W-1:0] st_rdata, rd_val;
    logic          blk, wake_req;
    logic [NREQ-1:0] pend_map;
    logic          do_rd, do_wr, stall_view;
    view_e         vw;

    assign vw         = view_e'(view_i);
    assign do_rd      = rd_i;
    assign do_wr      = wr_i & ~rd_i;
    assign stall_view = (vw == VW_Q_BLK);
    assign tail_a     = head + cnt[AW-1:0];
    assign newest_a   = tail_a - AW'(1);

    fcc_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(st_waddr),
        .wdata(wdata_i), .raddr(head), .rdata(st_rdata)
    );

    fcc_waitlist #(.NREQ(NREQ)) wait_i (
        .clk(clk), .rst_n(rst_n), .block_set(blk), .block_id(req_id_i),
        .wake_req(wake_req), .pend(pend_map), .wake(wake_o)
    );

    // Decode the access into next tag, pointer, store and response values.
    always_comb begin
        head_n = head; cnt_n = cnt;
        e_n = e_flag; f_n = f_flag; t_n = t_flag;
        st_we = 1'b0; st_waddr = tail_a;
        rd_val = '0; blk = 1'b0; wake_req = 1'b0;
        if (do_rd) begin
            case (vw)
                VW_RAW: rd_val = st_rdata;
                VW_TAG: begin
                    rd_val[0] = e_flag;
                    rd_val[1] = f_flag;
                    rd_val[16] = t_flag;
                    rd_val[17] = 1'b1;
                    rd_val[CNT_LSB +: CW] = cnt;
                    rd_val[LOG_LSB +: 8] = 8'(AW);
                end
                VW_Q_BLK, VW_Q_TRY: begin
                    f_n = 1'b0;
                    if (stall_view && e_flag) begin
                        blk = 1'b1;
                    end else begin
                        wake_req = 1'b1;
                        if (cnt != '0) begin
                            rd_val = st_rdata;
                            head_n = head + AW'(1);
                            cnt_n  = cnt - CW'(1);
                        end
                        if (cnt_n == '0) e_n = 1'b1;
                    end
                end
                VW_SEM_BL, VW_SEM_TR: rd_val = '0;
                default: rd_val = '1;
            endcase
        end else if (do_wr) begin
            case (vw)
                VW_RAW: begin
                    if (cnt != '0) begin
                        st_we = 1'b1;
                        st_waddr = newest_a;
                    end
                end
                VW_TAG: begin
                    t_n = wdata_i[16];
                    e_n = wdata_i[0];
                    f_n = wdata_i[1];
                    if (wdata_i[0]) cnt_n = '0;
                end
                VW_Q_BLK, VW_Q_TRY: begin
                    e_n = 1'b0;
                    if (stall_view && f_flag) begin
                        blk = 1'b1;
                    end else begin
                        wake_req = 1'b1;
                        if (cnt < CW'(DEPTH)) begin
                            st_we = 1'b1;
                            cnt_n = cnt + CW'(1);
                        end
                        if (cnt_n == CW'(DEPTH)) f_n = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Hold tag, pointers and registered responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0; cnt <= '0;
            e_flag <= 1'b1; f_flag <= 1'b0; t_flag <= 1'b0;
            rdata_o <= '0; block_o <= 1'b0;
        end else begin
            head <= head_n; cnt <= cnt_n;
            e_flag <= e_n; f_flag <= f_n; t_flag <= t_n;
            if (do_rd) rdata_o <= rd_val;
            block_o <= blk;
        end
    end
endmodule

// File: rtl/fcc_cell_chk.sv
// Checker for the tagged FIFO cell, bound to the top module below.
// Watches port behaviour, the count register and the waiting bitmap.
module fcc_cell_chk #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    parameter int NREQ   = 8,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        view_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              block_o,
    input logic [NREQ-1:0]   wake_o,
    input logic [CW-1:0]     cnt,
    input logic [NREQ-1:0]   pend
);
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    a_r8_stall_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        block_o |-> cnt == $past(cnt));
    a_r10_wake_empties_list: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_o) |-> pend == '0);
    a_r10_stall_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        block_o |-> wake_o == '0);
    a_r3_empty_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !rd_i && view_i == 3'd1 && wdata_i[0]) |=> cnt == '0);
    a_r5_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && view_i == 3'd3 && cnt != '0) |=> cnt == $past(cnt) - CW'(1));
    a_r11_sem_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_i || wr_i) && (view_i == 3'd4 || view_i == 3'd5)) |=> cnt == $past(cnt));
endmodule

bind fifo_comm_cell fcc_cell_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NREQ(NREQ)) chk_i (
    .clk(clk), .rst_n(rst_n), .view_i(view_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .block_o(block_o), .wake_o(wake_o),
    .cnt(cnt), .pend(pend_map)
);

// File: tb/fifo_comm_cell_tb_top.sv
// Directed bench for the tagged FIFO cell; one task per scenario.
module fifo_comm_cell_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  view = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [63:0] wdat = '0;
    logic [2:0]  rid = '0;
    logic [63:0] rdata_o;
    logic        block_o;
    logic [7:0]  wake_o;

    logic [63:0] lr;
    logic        lb;
    logic [7:0]  lw;
    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    fifo_comm_cell dut_i (
        .clk(clk), .rst_n(rst_n), .view_i(view), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdat), .req_id_i(rid), .rdata_o(rdata_o),
        .block_o(block_o), .wake_o(wake_o)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    // One access; outputs captured just after the edge that takes it.
    task automatic acc(input logic [2:0] v, input logic r, input logic w,
                       input logic [63:0] d, input logic [2:0] id);
        @(negedge clk);
        view = v; rd = r; wr = w; wdat = d; rid = id;
        @(posedge clk); #1;
        lr = rdata_o; lb = block_o; lw = wake_o;
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
    endtask

    function automatic logic [63:0] tagw(input logic e, input logic f, input logic t, input int c);
        return 64'(e) | (64'(f) << 1) | (64'(t) << 16) | (64'd1 << 17) |
               (64'(c) << 18) | (64'd3 << 28);
    endfunction

    task automatic tag_check(input string req, input logic [63:0] exp);
        acc(3'd1, 1'b1, 1'b0, '0, '0);
        check(req, lr, exp);
    endtask

    task automatic t_reset;
        tag_check("R1 reset tag", tagw(1, 0, 0, 0));
        check("R1 no stall after reset", 64'(lb), 64'd0);
    endtask

    task automatic t_push_pop;
        acc(3'd3, 0, 1, 64'hA1, 0);
        acc(3'd3, 0, 1, 64'hB2, 0);
        acc(3'd3, 0, 1, 64'hC3, 0);
        tag_check("R4 R2 tag after 3 pushes", tagw(0, 0, 0, 3));
        acc(3'd0, 1, 0, '0, 0);
        check("R6 raw peek head", lr, 64'hA1);
        tag_check("R6 peek keeps count", tagw(0, 0, 0, 3));
        acc(3'd0, 0, 1, 64'hEE, 0);
        acc(3'd3, 1, 0, '0, 0); check("R5 pop 1", lr, 64'hA1);
        acc(3'd3, 1, 0, '0, 0); check("R5 pop 2", lr, 64'hB2);
        acc(3'd3, 1, 0, '0, 0); check("R7 newest overwritten", lr, 64'hEE);
        tag_check("R5 empty after drain", tagw(1, 0, 0, 0));
        acc(3'd3, 1, 0, '0, 0);
        check("R5 pop empty returns 0", lr, 64'd0);
        check("R5 try pop never stalls", 64'(lb), 64'd0);
        acc(3'd0, 0, 1, 64'h77, 0);
        tag_check("R7 raw write at count 0 ignored", tagw(1, 0, 0, 0));
        acc(3'd0, 1, 0, '0, 0);
        check("R7 head entry untouched", lr, 64'd0);
    endtask

    task automatic t_full;
        for (int i = 0; i < 8; i++) acc(3'd3, 0, 1, 64'h100 + 64'(i), 0);
        tag_check("R4 full at depth", tagw(0, 1, 0, 8));
        acc(3'd3, 0, 1, 64'hBAD, 0);
        tag_check("R4 push when full dropped", tagw(0, 1, 0, 8));
        acc(3'd2, 0, 1, 64'hBAD2, 3'd5);
        check("R9 stalling push when full", 64'(lb), 64'd1);
        check("R10 stalled push no wake", 64'(lw), 64'd0);
        tag_check("R9 nothing stored", tagw(0, 1, 0, 8));
        acc(3'd3, 1, 0, '0, 0);
        check("R5 pop after full", lr, 64'h100);
        check("R10 wake requester 5", 64'(lw), 64'h20);
        tag_check("R5 full cleared", tagw(0, 0, 0, 7));
        for (int i = 1; i < 8; i++) begin
            acc(3'd3, 1, 0, '0, 0);
            check("R4 order after drop", lr, 64'h100 + 64'(i));
        end
        tag_check("R5 empty again", tagw(1, 0, 0, 0));
    endtask

    task automatic t_stall_read;
        acc(3'd2, 1, 0, '0, 3'd2);
        check("R8 stalling pop on empty", 64'(lb), 64'd1);
        check("R8 stalled read data", lr, 64'd0);
        acc(3'd2, 1, 0, '0, 3'd6);
        check("R8 second stall", 64'(lb), 64'd1);
        tag_check("R8 state kept", tagw(1, 0, 0, 0));
        acc(3'd2, 0, 1, 64'h5151, 3'd1);
        check("R10 push wakes 2 and 6", 64'(lw), 64'h44);
        check("R4 stalling push goes through", 64'(lb), 64'd0);
        acc(3'd2, 1, 0, '0, 3'd2);
        check("R5 retry pop data", lr, 64'h5151);
        check("R10 list cleared after wake", 64'(lw), 64'd0);
    endtask

    task automatic t_tag_write;
        acc(3'd3, 0, 1, 64'h1, 0);
        acc(3'd3, 0, 1, 64'h2, 0);
        acc(3'd1, 0, 1, (64'd1 << 16) | 64'd2, 0);
        tag_check("R3 flags forced", tagw(0, 1, 1, 2));
        acc(3'd2, 0, 1, 64'h9, 3'd3);
        check("R9 forced full stalls push", 64'(lb), 64'd1);
        acc(3'd1, 0, 1, 64'd1, 0);
        tag_check("R3 empty clears count", tagw(1, 0, 0, 0));
        acc(3'd1, 0, 1, 64'd0, 0);
        tag_check("R3 empty forced low", tagw(0, 0, 0, 0));
        acc(3'd2, 1, 0, '0, 3'd4);
        check("R5 pop count 0 returns 0", lr, 64'd0);
        check("R10 wake requester 3", 64'(lw), 64'h08);
        check("R8 no stall when empty flag low", 64'(lb), 64'd0);
        tag_check("R5 empty set at count 0", tagw(1, 0, 0, 0));
    endtask

    task automatic t_sem_undef;
        acc(3'd3, 0, 1, 64'hCAFE, 0);
        acc(3'd4, 1, 0, '0, 0); check("R11 sem read 0", lr, 64'd0);
        check("R11 sem read no stall", 64'(lb), 64'd0);
        acc(3'd5, 1, 0, '0, 0); check("R11 sem try read 0", lr, 64'd0);
        acc(3'd4, 0, 1, 64'h1, 0);
        acc(3'd5, 0, 1, 64'h1, 0);
        acc(3'd6, 1, 0, '0, 0); check("R12 undefined read ones", lr, '1);
        acc(3'd7, 0, 1, 64'hDEAD, 0);
        tag_check("R11 R12 state kept", tagw(0, 0, 0, 1));
        acc(3'd3, 1, 0, '0, 0); check("R12 entry intact", lr, 64'hCAFE);
    endtask

    task automatic t_rd_wr;
        acc(3'd3, 0, 1, 64'h4B, 0);
        acc(3'd3, 1, 1, 64'h99, 0);
        check("R13 read wins", lr, 64'h4B);
        tag_check("R13 write dropped", tagw(1, 0, 0, 0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_push_pop();
        t_full();
        t_stall_read();
        t_tag_write();
        t_sem_undef();
        t_rd_wr();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule